// File: doc/BRIEF.md
# Random-Access Correlation Peak Detector

This block sits behind the frequency-domain correlator of a random-access receiver. For every root sequence in a configured list it takes one pass of correlation samples per receive antenna. A pass holds the complex correlation value at each of the sequence positions. The block turns each sample into a power value and adds the powers of all antennas at the same position, so the antennas are combined without regard to phase. It keeps the largest combined value, the root that produced it and its position, across all roots of the window.

After the final sample of the window, the block emits a one-cycle result. The result carries a detect flag, set when the peak is strictly above a programmable threshold. It also carries the preamble number and the delay, both decoded from the winning root's list position and the peak's sample position. The decode uses the cyclic-shift spacing and needs no divider.

Top module: `prach_peak_detector`

## Requirements
- R1: The combined metric at a sample position is the sum over all antennas of re² + im² of that position's input, with re and im read as two's complement.
- R2: The reported peak is the largest combined metric over every root and every sample position of the window.
- R3: `res_detect` is 1 only when the peak metric is strictly greater than `cfg_threshold`. A peak equal to the threshold gives 0.
- R4: `res_id` equals PER_ROOT·r + floor(n/SHIFT_SPACING), where PER_ROOT = floor(SEQ_LEN/SHIFT_SPACING), r is the winning root's list position and n is the peak sample.
- R5: `res_delay` equals n mod SHIFT_SPACING for the peak sample n, and is always below SHIFT_SPACING.
- R6: Equal metrics keep the earlier entry: a lower root position wins, and within a root a lower sample index wins.
- R7: The tracked peak restarts at the first sample of each window, so no earlier window affects the result.
- R8: Input order within a window is root-major, then antenna, then ascending sample. `res_valid` is a one-cycle pulse two clock edges after the window's final sample (last root, last antenna, sample SEQ_LEN−1) is accepted.
- R9: While reset is asserted and after it is released, `res_valid` and `res_detect` are 0 until a window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Correlation sample present |
| in_root | input | ROOT_W | Position of the root in the root list |
| in_ant | input | ANT_W | Antenna index |
| in_sample | input | SAMP_W | Sample position within the sequence |
| in_re | input | DATA_W | Real part, signed |
| in_im | input | DATA_W | Imaginary part, signed |
| cfg_threshold | input | COMB_W | Detection threshold on the combined metric |
| res_valid | output | 1 | One-cycle result strobe |
| res_detect | output | 1 | Peak exceeded the threshold |
| res_id | output | ID_W | Decoded preamble number |
| res_delay | output | DLY_W | Delay in sample periods |

## Verification
The hardest situations to reach are those where the winner depends on how partial sums across antennas compare with a single strong antenna. Exact ties between roots are just as hard. Directed windows therefore place energy split over two antennas next to a larger single-antenna value. They also plant identical metrics in two roots and at a later sample of the first root. Back-to-back windows, the first carrying a large peak, show that the tracked maximum is cleared. A sample in the short tail beyond the last full shift exercises the wrap counter's final partial group.

// File: rtl/prach_pkg.sv
// Shared helpers for the random-access peak detector.
// Assumes: callers pass positive counts.
package prach_pkg;
    // Bits needed to index n items, at least one.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/prach_power_calc.sv
// Instantaneous power of one complex sample: re*re + im*im.
// Assumes: two's complement inputs; output wide enough for the extreme negative value.
module prach_power_calc #(
    parameter int DATA_W = 12,
    localparam int PWR_W = 2 * DATA_W
) (
    input  logic signed [DATA_W-1:0] re,
    input  logic signed [DATA_W-1:0] im,
    output logic        [PWR_W-1:0]  pwr
);
    logic signed [PWR_W:0] sq_re, sq_im;

    // Square each part and add; both squares are non-negative.
    always_comb begin
        sq_re = (PWR_W+1)'(re) * (PWR_W+1)'(re);
        sq_im = (PWR_W+1)'(im) * (PWR_W+1)'(im);
        pwr   = PWR_W'(sq_re + sq_im);
    end
endmodule

// File: rtl/prach_shift_counter.sv
// Tracks floor(n/SPACING) and n mod SPACING for an ascending sample stream.
// Assumes: positions step by one after a restart at sample zero.
module prach_shift_counter #(
    parameter int SPACING = 15,
    parameter int Q_W     = 6,
    parameter int R_W     = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           restart,
    output logic [Q_W-1:0] cur_q,
    output logic [R_W-1:0] cur_r
);
    logic [Q_W-1:0] prev_q;
    logic [R_W-1:0] prev_r;

    // Position of the current sample, derived from the previous one.
    always_comb begin
        if (restart) begin
            cur_q = '0;
            cur_r = '0;
        end else if (prev_r == R_W'(SPACING - 1)) begin
            cur_q = prev_q + 1'b1;
            cur_r = '0;
        end else begin
            cur_q = prev_q;
            cur_r = prev_r + 1'b1;
        end
    end

    // Remember the position of the sample just consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            prev_r <= '0;
        end else if (step) begin
            prev_q <= cur_q;
            prev_r <= cur_r;
        end
    end
endmodule

// File: rtl/prach_peak_detector.sv
// Non-coherent antenna combining, peak search over a root list, and decode
// of the peak into preamble number and delay.
// Assumes: root-major, then antenna, then ascending sample order in a window.
module prach_peak_detector #(
    parameter int SEQ_LEN       = 839,
    parameter int SHIFT_SPACING = 15,
    parameter int NUM_ANT       = 2,
    parameter int NUM_ROOTS     = 2,
    parameter int DATA_W        = 12,
    localparam int SAMP_W   = prach_pkg::idx_width(SEQ_LEN),
    localparam int ANT_W    = prach_pkg::idx_width(NUM_ANT),
    localparam int ROOT_W   = prach_pkg::idx_width(NUM_ROOTS),
    localparam int PWR_W    = 2 * DATA_W,
    localparam int COMB_W   = PWR_W + prach_pkg::idx_width(NUM_ANT),
    localparam int PER_ROOT = SEQ_LEN / SHIFT_SPACING,
    localparam int Q_W      = prach_pkg::idx_width(PER_ROOT + 1),
    localparam int ID_W     = prach_pkg::idx_width(NUM_ROOTS * (PER_ROOT + 1)),
    localparam int DLY_W    = prach_pkg::idx_width(SHIFT_SPACING)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [ROOT_W-1:0]        in_root,
    input  logic [ANT_W-1:0]         in_ant,
    input  logic [SAMP_W-1:0]        in_sample,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    input  logic [COMB_W-1:0]        cfg_threshold,
    output logic                     res_valid,
    output logic                     res_detect,
    output logic [ID_W-1:0]          res_id,
    output logic [DLY_W-1:0]         res_delay
);
    logic [PWR_W-1:0]  pwr_now;
    logic              s1_valid, s1_first, s1_final;
    logic [ROOT_W-1:0] s1_root;
    logic [ANT_W-1:0]  s1_ant;
    logic [SAMP_W-1:0] s1_sample;
    logic [PWR_W-1:0]  s1_pwr;

    logic [COMB_W-1:0] acc_mem [SEQ_LEN];
    logic [COMB_W-1:0] comb_sum;
    logic              last_ant, take;
    logic [Q_W-1:0]    cur_q;
    logic [DLY_W-1:0]  cur_r;

    logic              have_max;
    logic [COMB_W-1:0] max_val, peak_next;
    logic [ROOT_W-1:0] best_root, root_next;
    logic [Q_W-1:0]    best_q, q_next;
    logic [DLY_W-1:0]  best_r, r_next;

    prach_power_calc #(.DATA_W(DATA_W)) u_pwr (
        .re  (in_re),
        .im  (in_im),
        .pwr (pwr_now)
    );

    // Stage 1: register the power and the position of the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_first  <= 1'b0;
            s1_final  <= 1'b0;
            s1_root   <= '0;
            s1_ant    <= '0;
            s1_sample <= '0;
            s1_pwr    <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_first  <= in_valid && in_root == '0 && in_ant == '0 && in_sample == '0;
            s1_final  <= in_valid && in_root == ROOT_W'(NUM_ROOTS - 1)
                         && in_ant == ANT_W'(NUM_ANT - 1)
                         && in_sample == SAMP_W'(SEQ_LEN - 1);
            s1_root   <= in_root;
            s1_ant    <= in_ant;
            s1_sample <= in_sample;
            s1_pwr    <= pwr_now;
        end
    end

    // Stage 2 datapath: running antenna sum and the peak candidate.
    always_comb begin
        last_ant = s1_ant == ANT_W'(NUM_ANT - 1);
        comb_sum = (s1_ant == '0) ? COMB_W'(s1_pwr)
                                  : acc_mem[s1_sample] + COMB_W'(s1_pwr);
        take      = s1_valid && last_ant
                    && (!have_max || s1_first || comb_sum > max_val);
        peak_next = take ? comb_sum : max_val;
        root_next = take ? s1_root  : best_root;
        q_next    = take ? cur_q    : best_q;
        r_next    = take ? cur_r    : best_r;
    end

    // Per-sample accumulation buffer across antennas.
    always_ff @(posedge clk) begin
        if (s1_valid) acc_mem[s1_sample] <= comb_sum;
    end

    prach_shift_counter #(
        .SPACING (SHIFT_SPACING),
        .Q_W     (Q_W),
        .R_W     (DLY_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (s1_valid && last_ant),
        .restart (s1_sample == '0),
        .cur_q   (cur_q),
        .cur_r   (cur_r)
    );

    // Peak tracking: restart per window, strict compare keeps the earliest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_max  <= 1'b0;
            max_val   <= '0;
            best_root <= '0;
            best_q    <= '0;
            best_r    <= '0;
        end else begin
            if (take) have_max <= 1'b1;
            else if (s1_valid && s1_first) have_max <= 1'b0;
            max_val   <= peak_next;
            best_root <= root_next;
            best_q    <= q_next;
            best_r    <= r_next;
        end
    end

    // Result stage: threshold compare and decode on the final sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_detect <= 1'b0;
            res_id     <= '0;
            res_delay  <= '0;
        end else begin
            res_valid <= s1_valid && s1_final;
            if (s1_valid && s1_final) begin
                res_detect <= peak_next > cfg_threshold;
                res_id     <= ID_W'(root_next) * ID_W'(PER_ROOT) + ID_W'(q_next);
                res_delay  <= r_next;
            end else begin
                res_detect <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/prach_peak_detector_checker.sv
// Port-level properties of the peak detector, attached by bind.
// Assumes: the same parameters as the bound instance.
module prach_peak_detector_checker #(
    parameter int SEQ_LEN       = 839,
    parameter int SHIFT_SPACING = 15,
    parameter int NUM_ANT       = 2,
    parameter int NUM_ROOTS     = 2,
    parameter int ROOT_W        = 1,
    parameter int ANT_W         = 1,
    parameter int SAMP_W        = 10,
    parameter int DLY_W         = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ROOT_W-1:0] in_root,
    input logic [ANT_W-1:0]  in_ant,
    input logic [SAMP_W-1:0] in_sample,
    input logic              res_valid,
    input logic              res_detect,
    input logic [DLY_W-1:0]  res_delay
);
    logic final_in;
    logic seen1;

    // Final sample of a window as seen at the input ports.
    always_comb begin
        final_in = in_valid && in_root == ROOT_W'(NUM_ROOTS - 1)
                   && in_ant == ANT_W'(NUM_ANT - 1)
                   && in_sample == SAMP_W'(SEQ_LEN - 1);
    end

    // Marks that at least one cycle has elapsed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen1 <= 1'b0;
        else        seen1 <= 1'b1;
    end

    assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> seen1 && $past(final_in, 2));

    assert_delay_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_delay < DLY_W'(SHIFT_SPACING));

    assert_detect_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_detect |-> res_valid);

    assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !seen1 |-> !res_valid && !res_detect);
endmodule

bind prach_peak_detector prach_peak_detector_checker #(
    .SEQ_LEN       (SEQ_LEN),
    .SHIFT_SPACING (SHIFT_SPACING),
    .NUM_ANT       (NUM_ANT),
    .NUM_ROOTS     (NUM_ROOTS),
    .ROOT_W        (ROOT_W),
    .ANT_W         (ANT_W),
    .SAMP_W        (SAMP_W),
    .DLY_W         (DLY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_root    (in_root),
    .in_ant     (in_ant),
    .in_sample  (in_sample),
    .res_valid  (res_valid),
    .res_detect (res_detect),
    .res_delay  (res_delay)
);

// File: tb/prach_peak_detector_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module prach_peak_detector_tb;
    localparam int N  = 31;
    localparam int S  = 7;
    localparam int NA = 2;
    localparam int NR = 2;
    localparam int DW = 12;
    localparam int CW = 2 * DW + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [0:0]           in_root = '0;
    logic [0:0]           in_ant = '0;
    logic [4:0]           in_sample = '0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic [CW-1:0]        cfg_threshold = '0;
    logic                 res_valid, res_detect;
    logic [3:0]           res_id;
    logic [2:0]           res_delay;

    int checks = 0;
    int errors = 0;
    logic signed [DW-1:0] pat_re [NR][NA][N];
    logic signed [DW-1:0] pat_im [NR][NA][N];
    logic       got_valid, got_detect, got_after;
    logic [3:0] got_id;
    logic [2:0] got_delay;

    always #4 clk = ~clk;

    prach_peak_detector #(
        .SEQ_LEN(N), .SHIFT_SPACING(S), .NUM_ANT(NA), .NUM_ROOTS(NR), .DATA_W(DW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_root(in_root),
        .in_ant(in_ant), .in_sample(in_sample), .in_re(in_re), .in_im(in_im),
        .cfg_threshold(cfg_threshold), .res_valid(res_valid),
        .res_detect(res_detect), .res_id(res_id), .res_delay(res_delay)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_pattern();
        for (int r = 0; r < NR; r++)
            for (int a = 0; a < NA; a++)
                for (int n = 0; n < N; n++) begin
                    pat_re[r][a][n] = '0;
                    pat_im[r][a][n] = '0;
                end
    endtask

    task automatic put(input int r, input int a, input int n, input int re, input int im);
        pat_re[r][a][n] = DW'(re);
        pat_im[r][a][n] = DW'(im);
    endtask

    // Stream one full window, then capture the result pulse and the cycle after.
    task automatic run_window(input int thr);
        cfg_threshold = CW'(thr);
        for (int r = 0; r < NR; r++)
            for (int a = 0; a < NA; a++)
                for (int n = 0; n < N; n++) begin
                    @(negedge clk);
                    in_valid  = 1'b1;
                    in_root   = 1'(r);
                    in_ant    = 1'(a);
                    in_sample = 5'(n);
                    in_re     = pat_re[r][a][n];
                    in_im     = pat_im[r][a][n];
                end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        got_valid  = res_valid;
        got_detect = res_detect;
        got_id     = res_id;
        got_delay  = res_delay;
        @(negedge clk);
        got_after = res_valid;
        check("R8 result strobe", int'(got_valid), 1);
        check("R8 strobe one cycle", int'(got_after), 0);
    endtask

    task automatic test_reset();
        check("R9 valid in reset", int'(res_valid), 0);
        check("R9 detect in reset", int'(res_detect), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 valid after reset", int'(res_valid), 0);
    endtask

    task automatic test_single_peak();
        clear_pattern();
        put(1, 0, 17, 100, -50);
        put(1, 1, 17, 20, 0);
        put(0, 0, 4, 50, 50);
        run_window(1000);
        check("R2 detect", int'(got_detect), 1);
        check("R4 id", int'(got_id), 6);
        check("R5 delay", int'(got_delay), 3);
    endtask

    task automatic test_combine();
        clear_pattern();
        put(0, 0, 5, 3, 0);
        put(0, 1, 5, 0, -4);
        put(0, 0, 9, 4, 2);
        run_window(24);
        check("R1 combined beats single", int'(got_delay), 5);
        check("R1 id", int'(got_id), 0);
        check("R1 detect sum 25 over 24", int'(got_detect), 1);
    endtask

    task automatic test_threshold();
        clear_pattern();
        put(0, 1, 12, 10, 10);
        run_window(200);
        check("R3 equal gives no detect", int'(got_detect), 0);
        check("R4 id without detect", int'(got_id), 1);
        check("R5 delay without detect", int'(got_delay), 5);
        run_window(199);
        check("R3 above gives detect", int'(got_detect), 1);
    endtask

    task automatic test_tie();
        clear_pattern();
        put(0, 0, 10, 6, 8);
        put(1, 1, 3, -8, 6);
        put(0, 1, 24, 10, 0);
        run_window(0);
        check("R6 tie id", int'(got_id), 1);
        check("R6 tie delay", int'(got_delay), 3);
    endtask

    task automatic test_window_restart();
        clear_pattern();
        put(1, 0, 17, 100, -50);
        run_window(0);
        clear_pattern();
        put(0, 0, 30, 0, 5);
        run_window(0);
        check("R7 new window id", int'(got_id), 4);
        check("R7 new window delay", int'(got_delay), 2);
        clear_pattern();
        run_window(0);
        check("R7 zero window id", int'(got_id), 0);
        check("R7 zero window delay", int'(got_delay), 0);
        check("R3 zero peak no detect", int'(got_detect), 0);
    endtask

    initial begin
        fork
            begin
                test_reset();
                test_single_peak();
                test_combine();
                test_threshold();
                test_tie();
                test_window_restart();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule